// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether a multicast destination address belongs to a group the station has subscribed to. It takes the two final bytes of a 48-bit destination address and cuts a 12-bit window out of them. The position of that window is set by a two-bit filter type. The window value is the hash. It selects one bit of a 4096-bit table, and that bit gives the verdict.

Software fills the table one 32-bit word at a time over a plain write port. A single clear strobe wipes every word at once. Software also loads the filter type into a configuration register. A lookup is one strobe carrying the address. The result appears in the cycle after that strobe.

The output side is a small decision state machine. It has four named states:
- `DEC_IDLE`: no result this cycle.
- `DEC_ACCEPT`: a multicast address whose table bit is 1.
- `DEC_REJECT`: a multicast address whose table bit is 0.
- `DEC_FOREIGN`: the address is not multicast.

Every clock edge with `lk_valid` high moves the machine into one of the last three states:
- to `DEC_FOREIGN` when the group bit is 0;
- otherwise to `DEC_ACCEPT` or `DEC_REJECT`, following the table bit.

Every edge with `lk_valid` low moves it to `DEC_IDLE`. Any state can reach any other in one edge.

Top module: `mc_hash_filter`

## Requirements
- R1: The address is presented as `lk_addr[47:0]`, with its first byte in bits 47:40 and its last byte in bits 7:0. Let W = {last byte, fifth byte} = `lk_addr[7:0]`,`lk_addr[15:8]`. The hash is (W >> (8 - s)) truncated to 12 bits, where s = 4 + {0, 1, 2, 4} for filter types 0, 1, 2 and 3. For bytes 0x34, 0x56 this gives 0x563, 0xAC6, 0x58D and 0x634.
- R2: Table word `tbl_idx` (7 bits) is written with the full 32-bit `tbl_wdata` when `tbl_we` is high. A hash selects word hash[11:5] and bit hash[4:0] of that word.
- R3: When the address is multicast, the result is `res_accept`=1 if the selected table bit is 1 and `res_accept`=0 if it is 0. In both cases `res_multicast`=1.
- R4: When bit 40 of `lk_addr` (bit 0 of the first byte) is 0, the result is `res_multicast`=0 and `res_accept`=0, whatever the table holds.
- R5: `res_valid` is 1 in exactly the cycle after each cycle with `lk_valid`=1, and 0 otherwise. Back-to-back lookups give back-to-back results.
- R6: `tbl_clear` sets every table word to zero in one cycle. It wins over a `tbl_we` in the same cycle.
- R7: `cfg_we` loads `cfg_ftype` into the filter-type register. A lookup in the same cycle as that load still uses the previous type. The next lookup uses the new type.
- R8: A lookup in the same cycle as a table write or clear sees the table as it was before that edge.
- R9: After reset, `res_valid`=0, `res_accept`=0, `res_multicast`=0, the table is all zero and the filter type is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the filter-type register |
| cfg_ftype | input | 2 | New filter type |
| tbl_clear | input | 1 | Zero the whole table |
| tbl_we | input | 1 | Write one table word |
| tbl_idx | input | 7 | Table word index |
| tbl_wdata | input | 32 | Table word data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, first byte in the top bits |
| res_valid | output | 1 | Result present this cycle |
| res_accept | output | 1 | Address is a subscribed multicast group |
| res_multicast | output | 1 | Address had its group bit set |

## Verification
The assertions assume that `lk_addr` and `lk_valid` are known (not X) whenever reset is released. They also assume that a table write presents an index below the word count. The stimulus keeps to both:
- inputs are driven only on falling edges;
- they are parked at zero when idle;
- every write index comes from a 7-bit hash field or a literal below 128.

The same-edge cases (type load with lookup, write with lookup, clear with write) are driven on purpose, because the ordering rules only show there.

// File: rtl/mchf_pkg.sv
package mchf_pkg;

    typedef enum logic [1:0] {
        FT_BASE  = 2'd0,
        FT_PLUS1 = 2'd1,
        FT_PLUS2 = 2'd2,
        FT_PLUS4 = 2'd3
    } ftype_e;

    typedef enum logic [1:0] {
        DEC_IDLE    = 2'd0,
        DEC_ACCEPT  = 2'd1,
        DEC_REJECT  = 2'd2,
        DEC_FOREIGN = 2'd3
    } dec_e;

    localparam int N_FTYPES = 4;

    // Extra left shift of the last byte contributed by each filter type.
    function automatic int extra_shift(input int k);
        return (k == 3) ? 4 : k;
    endfunction

endpackage

// File: rtl/mchf_hash.sv
module mchf_hash
    import mchf_pkg::*;
#(
    parameter int HASH_W = 12
) (
    input  logic [7:0]        byte_hi,
    input  logic [7:0]        byte_lo,
    input  ftype_e            ftype,
    output logic [HASH_W-1:0] hash
);
    localparam int BASE = HASH_W - 8;

    logic [15:0]       window;
    logic [HASH_W-1:0] tap [N_FTYPES];

    assign window = {byte_hi, byte_lo};

    // One fixed tap per filter type; a shifted window needs no barrel shifter.
    for (genvar k = 0; k < N_FTYPES; k++) begin : g_tap
        localparam int SH = BASE + extra_shift(k);
        assign tap[k] = HASH_W'(window >> (8 - SH));
    end

    always_comb begin
        hash = tap[ftype];
    end

endmodule

// File: rtl/mchf_table.sv
module mchf_table #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    input  logic [BIT_W-1:0]  rbit,
    output logic              rhit
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  word_sel;

    for (genvar g = 0; g < WORDS; g++) begin : g_sel
        assign word_sel[g] = we && (widx == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (clear) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (word_sel[i]) mem[i] <= wdata;
            end
        end
    end

    // Combinational read: a lookup sees the contents before the edge.
    assign rhit = mem[ridx][rbit];

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mem[0] == '0) && (mem[WORDS-1] == '0) && (mem[$past(widx)] == '0));

    assert_word_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear) |=> (mem[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/mchf_decide.sv
module mchf_decide
    import mchf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_valid,
    input  logic is_mc,
    input  logic hit,
    output logic res_valid,
    output logic res_accept,
    output logic res_multicast
);
    dec_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!lk_valid)  state_d = DEC_IDLE;
        else if (!is_mc) state_d = DEC_FOREIGN;
        else if (hit)   state_d = DEC_ACCEPT;
        else            state_d = DEC_REJECT;
    end

    always_comb begin
        res_valid     = 1'b0;
        res_accept    = 1'b0;
        res_multicast = 1'b0;
        unique case (state_q)
            DEC_IDLE: ;
            DEC_ACCEPT: begin
                res_valid     = 1'b1;
                res_accept    = 1'b1;
                res_multicast = 1'b1;
            end
            DEC_REJECT: begin
                res_valid     = 1'b1;
                res_multicast = 1'b1;
            end
            DEC_FOREIGN: begin
                res_valid = 1'b1;
            end
        endcase
    end

    assert_hit_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && is_mc) |=> (res_accept == $past(hit)) && res_multicast);

endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
    import mchf_pkg::*;
#(
    parameter int REG_COUNT = 128,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(REG_COUNT),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int HASH_W   = $clog2(REG_COUNT * WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_ftype,
    input  logic              tbl_clear,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              lk_valid,
    input  logic [47:0]       lk_addr,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_multicast
);
    ftype_e            ftype_q;
    logic [HASH_W-1:0] hash;
    logic              hit;
    logic              is_mc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ftype_q <= FT_BASE;
        else if (cfg_we) ftype_q <= ftype_e'(cfg_ftype);
    end

    assign is_mc = lk_addr[40];

    mchf_hash #(.HASH_W(HASH_W)) u_hash (
        .byte_hi (lk_addr[7:0]),
        .byte_lo (lk_addr[15:8]),
        .ftype   (ftype_q),
        .hash    (hash)
    );

    mchf_table #(.WORDS(REG_COUNT), .WORD_W(WORD_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tbl_clear),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wdata (tbl_wdata),
        .ridx  (hash[HASH_W-1:BIT_W]),
        .rbit  (hash[BIT_W-1:0]),
        .rhit  (hit)
    );

    mchf_decide u_decide (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .is_mc         (is_mc),
        .hit           (hit),
        .res_valid     (res_valid),
        .res_accept    (res_accept),
        .res_multicast (res_multicast)
    );

    assert_result_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_foreign_rejects_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_addr[40]) |=> (!res_accept && !res_multicast));

    assert_type_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ftype_q));

    assert_type_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ftype_q == ftype_e'($past(cfg_ftype))));

endmodule

// File: tb/mc_hash_filter_tb.sv
module mc_hash_filter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ftype = '0;
    logic        tbl_clear = 1'b0;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_idx = '0;
    logic [31:0] tbl_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_valid, res_accept, res_multicast;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_hash_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ftype(cfg_ftype),
        .tbl_clear(tbl_clear), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_accept(res_accept),
        .res_multicast(res_multicast)
    );

    typedef struct packed {
        logic [1:0]  ft;
        logic [47:0] addr;
        logic [11:0] hash;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 48'h01AA00123456, 12'h563},
        '{2'd1, 48'h01AA00123456, 12'hAC6},
        '{2'd2, 48'h01AA00123456, 12'h58D},
        '{2'd3, 48'h01AA00123456, 12'h634},
        '{2'd0, 48'h01005E0000FF, 12'hFF0},
        '{2'd3, 48'h03000000CDAB, 12'hBCD},
        '{2'd1, 48'h010203048001, 12'h030},
        '{2'd2, 48'h7F000000FFFF, 12'hFFF},
        '{2'd0, 48'h0100000F0F00, 12'h000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks enter and leave just after a falling edge.
    task automatic set_type(input logic [1:0] t);
        cfg_we = 1'b1; cfg_ftype = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_word(input logic [6:0] idx, input logic [31:0] d);
        tbl_we = 1'b1; tbl_idx = idx; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic clear_tbl();
        tbl_clear = 1'b1;
        @(negedge clk);
        tbl_clear = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] a);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0; lk_addr = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 res_valid in reset", 32'(res_valid), 0);
        chk("R9 res_accept in reset", 32'(res_accept), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 res_valid after reset", 32'(res_valid), 0);
        // R9: empty table and type 0 after reset
        lookup(48'h01AA00123456);
        chk("R9 empty table rejects", 32'(res_accept), 0);
        write_word(7'h2B, 32'h0000_0008);
        lookup(48'h01AA00123456);
        chk("R9 default type 0 hash 563", 32'(res_accept), 1);

        // R1 R2 R3: vector walk
        for (int v = 0; v < NV; v++) begin
            clear_tbl();
            set_type(VECS[v].ft);
            write_word(VECS[v].hash[11:5], 32'(1) << VECS[v].hash[4:0]);
            lookup(VECS[v].addr);
            chk($sformatf("R1 R2 R3 vec%0d accept", v), 32'(res_accept), 1);
            chk($sformatf("R3 vec%0d multicast", v), 32'(res_multicast), 1);
            write_word(VECS[v].hash[11:5], ~(32'(1) << VECS[v].hash[4:0]));
            lookup(VECS[v].addr);
            chk($sformatf("R2 R3 vec%0d reject other bits", v), 32'(res_accept), 0);
        end

        // R4: not multicast, table all ones for that word
        clear_tbl();
        set_type(2'd0);
        write_word(7'h2B, 32'hFFFF_FFFF);
        lookup(48'h00AA00123456);
        chk("R4 valid", 32'(res_valid), 1);
        chk("R4 multicast flag", 32'(res_multicast), 0);
        chk("R4 accept", 32'(res_accept), 0);

        // R5: no result without strobe, back-to-back results
        @(negedge clk);
        chk("R5 idle no result", 32'(res_valid), 0);
        lk_valid = 1'b1; lk_addr = 48'h01AA00123456;
        @(negedge clk);
        chk("R5 b2b first valid", 32'(res_valid), 1);
        chk("R5 b2b first accept", 32'(res_accept), 1);
        lk_addr = 48'h0100000F0F00;
        @(negedge clk);
        lk_valid = 1'b0; lk_addr = '0;
        chk("R5 b2b second valid", 32'(res_valid), 1);
        chk("R5 b2b second reject", 32'(res_accept), 0);
        @(negedge clk);
        chk("R5 drops after", 32'(res_valid), 0);

        // R6: clear wins over a simultaneous write
        tbl_clear = 1'b1; tbl_we = 1'b1; tbl_idx = 7'h2B; tbl_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        tbl_clear = 1'b0; tbl_we = 1'b0;
        lookup(48'h01AA00123456);
        chk("R6 clear beats write", 32'(res_accept), 0);

        // R8: lookup in the write cycle sees old table
        tbl_we = 1'b1; tbl_idx = 7'h2B; tbl_wdata = 32'h0000_0008;
        lk_valid = 1'b1; lk_addr = 48'h01AA00123456;
        @(negedge clk);
        tbl_we = 1'b0; lk_valid = 1'b0; lk_addr = '0;
        chk("R8 same-cycle write unseen", 32'(res_accept), 0);
        lookup(48'h01AA00123456);
        chk("R8 write seen next", 32'(res_accept), 1);

        // R7: type load with lookup uses old type (0 -> hash 563 set)
        cfg_we = 1'b1; cfg_ftype = 2'd3;
        lk_valid = 1'b1; lk_addr = 48'h01AA00123456;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0; lk_addr = '0;
        chk("R7 old type in load cycle", 32'(res_accept), 1);
        lookup(48'h01AA00123456);
        chk("R7 new type afterwards", 32'(res_accept), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule